// File: doc/BRIEF.md
# External Bus Strobe Sequencer

This block produces the two timing strobes of an 8051-style multiplexed external memory bus: an active-high address-latch pulse and an active-low program-read strobe. A divide-by-two phase flop and a state counter, both clocked from the oscillator, form a machine cycle of twelve oscillator clocks. Each strobe is decoded from fixed positions inside that cycle. The CPU core reports the type of the next machine cycle: external data access, code-table read, or execution from external program memory. The block samples that report once per cycle boundary and uses it to drop the strobes that a data access must not see.

Software can stop the latch pulse by setting one register bit. When the bit takes effect, the latch output stays low and a weak-pullup request goes high instead. Several conditions suspend the bit: a cycle that executes from external program memory, a data access, a code-table read, idle, power-down and emulation. During a suspension the pullup request is released and pulsing resumes. A reset clears the bit. The reset input passes through a filter, so it acts only after it has been held high for two whole machine cycles.

Top module: `xbus_strobe_seq`

## Requirements
- R1: After a reset ends, position t counts oscillator clocks within the machine cycle (0 to 11, with t=0 first). In an ordinary cycle `ale` is high at t=1,2 and t=7,8 and low at every other position, which gives two pulses per twelve clocks.
- R2: In a cycle marked as an external data access, the second latch pulse (t=7,8) is dropped, and `psen_n` stays high for the whole cycle.
- R3: In a cycle marked as external execution that is not a data access, `psen_n` is low at t=3..5 and t=9..11 and high elsewhere. In a cycle without external execution it stays high.
- R4: `cyc_xdata`, `cyc_code_rd` and `cyc_ext_exec` are sampled on the clock edge that ends position t=11. The sampled values apply to the whole following machine cycle.
- R5: A write with `sfr_addr`=8'h8E loads bit 0 of `sfr_wdata` into the disable bit. The other data bits, and writes to any other address, have no effect. `sfr_rdata` returns {7'b0, disable bit} when `sfr_addr`=8'h8E and returns 0 for any other address.
- R6: The disable is in force when the bit is set and no suspension applies. While it is in force, `ale` stays low and `ale_wpu` is high.
- R7: Any of these suspends the disable: a sampled external execution, data access or code-table read cycle, `mode_idle`, `mode_pdown`, or `mode_emu`. During a suspension `ale_wpu` is low and `ale` follows R1 and R2.
- R8: While `mode_idle` or `mode_pdown` is high, `ale` is low and `psen_n` is high.
- R9: When `rst_in` has been high for 24 consecutive clocks, the block resets: the cycle position returns to t=0, the sampled cycle type clears, and the disable bit clears. While the reset lasts, `ale` is 0, `psen_n` is 1 and `ale_wpu` is 0. A shorter high pulse on `rst_in` changes nothing.
- R10: While `arst_n` is low, `ale` is 0, `psen_n` is 1, `ale_wpu` is 0 and the disable bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock |
| arst_n | input | 1 | Asynchronous power-on reset, active low |
| rst_in | input | 1 | Reset request, filtered over two machine cycles |
| cyc_xdata | input | 1 | Next machine cycle accesses external data memory |
| cyc_code_rd | input | 1 | Next machine cycle is a code-table read |
| cyc_ext_exec | input | 1 | Next machine cycle executes from external program memory |
| mode_idle | input | 1 | Idle mode active |
| mode_pdown | input | 1 | Power-down mode active |
| mode_emu | input | 1 | Emulation mode active |
| sfr_we | input | 1 | Register write strobe |
| sfr_addr | input | 8 | Register address for reads and writes |
| sfr_wdata | input | 8 | Register write data |
| sfr_rdata | output | 8 | Register read data |
| ale | output | 1 | Address-latch pulse, active high |
| psen_n | output | 1 | Program-read strobe, active low |
| ale_wpu | output | 1 | Request to pull the latch pin weakly high |

## Verification
An error in the phase flop or the state counter moves a latch edge into a slot it does not belong to. The per-clock comparison reports this within one machine cycle, and the pulse-width properties report it on the clock that follows the bad slot. If the sampled cycle type is wrong, the result is a missing or extra strobe for the whole of the next cycle, so the error appears at most twelve clocks after the bad boundary. A stuck disable bit or a stuck reset counter appears on `ale_wpu` and on the register read data one clock after the write or reset that should have changed it.

// File: rtl/xbs_pkg.sv
package xbs_pkg;

   // Kind of the current machine cycle, captured at each cycle boundary
   typedef struct packed {
      logic xdata;
      logic code_rd;
      logic ext_exec;
   } cyc_kind_t;

   localparam cyc_kind_t KIND_NONE = '0;

   // Output strobe bundle
   typedef struct packed {
      logic ale;
      logic psen_n;
      logic wpu;
   } strobe_t;

   localparam strobe_t STROBE_IDLE = '{ale: 1'b0, psen_n: 1'b1, wpu: 1'b0};

endpackage

// File: rtl/xbs_timebase.sv
module xbs_timebase #(
   parameter int STATES = 6,
   parameter int SW     = $clog2(STATES)
) (
   input  logic          clk,
   input  logic          arst_n,
   input  logic          srst,
   output logic          phase_o,
   output logic [SW-1:0] state_o,
   output logic          cyc_end_o
);

   localparam logic [SW-1:0] LAST = SW'(STATES - 1);

   logic          phase_q;
   logic [SW-1:0] state_q;

   // divide-by-two phase flop; the state advances after the second phase
   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         phase_q <= 1'b0;
         state_q <= '0;
      end else if (srst) begin
         phase_q <= 1'b0;
         state_q <= '0;
      end else begin
         phase_q <= ~phase_q;
         if (phase_q) begin
            state_q <= (state_q == LAST) ? '0 : state_q + 1'b1;
         end
      end
   end

   assign phase_o   = phase_q;
   assign state_o   = state_q;
   assign cyc_end_o = phase_q && (state_q == LAST);

endmodule

// File: rtl/xbs_rst_filter.sv
module xbs_rst_filter #(
   parameter int LIMIT = 24,
   parameter int CW    = $clog2(LIMIT + 1)
) (
   input  logic clk,
   input  logic arst_n,
   input  logic rst_in,
   output logic active_o
);

   localparam logic [CW-1:0] TOP = CW'(LIMIT);

   logic [CW-1:0] cnt_q;

   // count consecutive high samples and stop at the limit
   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         cnt_q <= '0;
      end else if (!rst_in) begin
         cnt_q <= '0;
      end else if (cnt_q != TOP) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign active_o = (cnt_q == TOP);

endmodule

// File: rtl/xbs_dis_reg.sv
module xbs_dis_reg #(
   parameter int            AW   = 8,
   parameter int            DW   = 8,
   parameter logic [AW-1:0] ADDR = 8'h8E,
   parameter int            BIT  = 0
) (
   input  logic          clk,
   input  logic          arst_n,
   input  logic          srst,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   output logic          dis_o
);

   logic dis_q;
   logic hit;
   logic unused_wbits;

   assign hit          = (addr == ADDR);
   assign unused_wbits = ^wdata;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         dis_q <= 1'b0;
      end else if (srst) begin
         dis_q <= 1'b0;
      end else if (we && hit) begin
         dis_q <= wdata[BIT];
      end
   end

   always_comb begin
      rdata = '0;
      if (hit) begin
         rdata[BIT] = dis_q;
      end
   end

   assign dis_o = dis_q;

endmodule

// File: rtl/xbs_strobe_gen.sv
module xbs_strobe_gen
   import xbs_pkg::*;
#(
   parameter int STATES  = 6,
   parameter int SW      = $clog2(STATES),
   parameter bit REG_OUT = 1'b0
) (
   input  logic          clk,
   input  logic          arst_n,
   input  logic          phase,
   input  logic [SW-1:0] state,
   input  cyc_kind_t     kind,
   input  logic          lowpwr,
   input  logic          dis_force,
   input  logic          hold,
   output strobe_t       strb_o
);

   localparam int HALF = STATES / 2;

   logic [1:0] ale_h;
   logic [1:0] psen_h;
   logic       ale_any;
   logic       psen_low;
   strobe_t    strb_c;

   // each half of the machine cycle carries one latch pulse and one read slot
   for (genvar h = 0; h < 2; h++) begin : g_half
      localparam int BASE = h * HALF;
      logic in_ale;
      logic in_psen;
      assign in_ale  = ((state == SW'(BASE)) && phase) ||
                       ((state == SW'(BASE + 1)) && !phase);
      assign in_psen = ((state == SW'(BASE + 1)) && phase) ||
                       ((state >= SW'(BASE + 2)) && (state <= SW'(BASE + HALF - 1)));
      if (h == 0) begin : g_first
         assign ale_h[h] = in_ale;
      end else begin : g_second
         assign ale_h[h] = in_ale && !kind.xdata;
      end
      assign psen_h[h] = in_psen;
   end

   assign ale_any  = |ale_h;
   assign psen_low = kind.ext_exec && !kind.xdata && (|psen_h) && !lowpwr && !hold;

   always_comb begin
      strb_c.ale    = ale_any && !dis_force && !lowpwr && !hold;
      strb_c.psen_n = !psen_low;
      strb_c.wpu    = dis_force && !hold;
   end

   if (REG_OUT) begin : g_reg_out
      strobe_t strb_q;
      always_ff @(posedge clk or negedge arst_n) begin
         if (!arst_n) begin
            strb_q <= STROBE_IDLE;
         end else begin
            strb_q <= strb_c;
         end
      end
      assign strb_o = strb_q;
   end else begin : g_comb_out
      assign strb_o = strb_c;
   end

endmodule

// File: rtl/xbus_strobe_seq.sv
module xbus_strobe_seq
   import xbs_pkg::*;
#(
   parameter int                STATES_PER_CYC   = 6,
   parameter int                PHASES_PER_STATE = 2,
   parameter int                RESET_MCYC       = 2,
   parameter int                SFR_AW           = 8,
   parameter int                SFR_DW           = 8,
   parameter logic [SFR_AW-1:0] DIS_ADDR         = 8'h8E,
   parameter int                DIS_BIT          = 0,
   parameter bit                REG_OUT          = 1'b0
) (
   input  logic              clk_osc,
   input  logic              arst_n,
   input  logic              rst_in,
   input  logic              cyc_xdata,
   input  logic              cyc_code_rd,
   input  logic              cyc_ext_exec,
   input  logic              mode_idle,
   input  logic              mode_pdown,
   input  logic              mode_emu,
   input  logic              sfr_we,
   input  logic [SFR_AW-1:0] sfr_addr,
   input  logic [SFR_DW-1:0] sfr_wdata,
   output logic [SFR_DW-1:0] sfr_rdata,
   output logic              ale,
   output logic              psen_n,
   output logic              ale_wpu
);

   localparam int CYC_CLKS = STATES_PER_CYC * PHASES_PER_STATE;
   localparam int RST_CLKS = RESET_MCYC * CYC_CLKS;
   localparam int SW       = $clog2(STATES_PER_CYC);

   // elaboration-time parameter checks
   if (PHASES_PER_STATE != 2) begin : g_chk_phase
      $error("phase stage is a divide-by-two; PHASES_PER_STATE must be 2");
   end
   if ((STATES_PER_CYC < 6) || (STATES_PER_CYC % 2 != 0)) begin : g_chk_states
      $error("STATES_PER_CYC must be even and at least 6");
   end
   if (RESET_MCYC < 1) begin : g_chk_rst
      $error("RESET_MCYC must be at least 1");
   end
   if ((DIS_BIT < 0) || (DIS_BIT >= SFR_DW)) begin : g_chk_bit
      $error("DIS_BIT outside the register width");
   end

   logic          rst_active;
   logic          phase;
   logic [SW-1:0] state;
   logic          cyc_end;
   logic          dis_q;
   cyc_kind_t     kind_q;
   logic          suspend;
   logic          lowpwr;
   logic          dis_force;
   strobe_t       strb;

   xbs_rst_filter #(.LIMIT(RST_CLKS)) u_rst (
      .clk      (clk_osc),
      .arst_n   (arst_n),
      .rst_in   (rst_in),
      .active_o (rst_active)
   );

   xbs_timebase #(.STATES(STATES_PER_CYC), .SW(SW)) u_tb (
      .clk       (clk_osc),
      .arst_n    (arst_n),
      .srst      (rst_active),
      .phase_o   (phase),
      .state_o   (state),
      .cyc_end_o (cyc_end)
   );

   xbs_dis_reg #(
      .AW   (SFR_AW),
      .DW   (SFR_DW),
      .ADDR (DIS_ADDR),
      .BIT  (DIS_BIT)
   ) u_dis (
      .clk    (clk_osc),
      .arst_n (arst_n),
      .srst   (rst_active),
      .we     (sfr_we),
      .addr   (sfr_addr),
      .wdata  (sfr_wdata),
      .rdata  (sfr_rdata),
      .dis_o  (dis_q)
   );

   // cycle type is taken once, on the edge that closes the machine cycle
   always_ff @(posedge clk_osc or negedge arst_n) begin
      if (!arst_n) begin
         kind_q <= KIND_NONE;
      end else if (rst_active) begin
         kind_q <= KIND_NONE;
      end else if (cyc_end) begin
         kind_q <= '{xdata: cyc_xdata, code_rd: cyc_code_rd, ext_exec: cyc_ext_exec};
      end
   end

   assign lowpwr    = mode_idle || mode_pdown;
   assign suspend   = kind_q.ext_exec || kind_q.xdata || kind_q.code_rd || lowpwr || mode_emu;
   assign dis_force = dis_q && !suspend;

   xbs_strobe_gen #(
      .STATES  (STATES_PER_CYC),
      .SW      (SW),
      .REG_OUT (REG_OUT)
   ) u_gen (
      .clk       (clk_osc),
      .arst_n    (arst_n),
      .phase     (phase),
      .state     (state),
      .kind      (kind_q),
      .lowpwr    (lowpwr),
      .dis_force (dis_force),
      .hold      (rst_active),
      .strb_o    (strb)
   );

   assign ale     = strb.ale;
   assign psen_n  = strb.psen_n;
   assign ale_wpu = strb.wpu;

endmodule

// File: rtl/xbs_checker.sv
module xbs_checker #(
   parameter int RST_CLKS = 24
) (
   input logic clk,
   input logic arst_n,
   input logic rst_in,
   input logic mode_idle,
   input logic mode_pdown,
   input logic ale,
   input logic psen_n,
   input logic ale_wpu,
   input logic dis_q
);

   int rcnt;

   // independent count of consecutive reset-request samples
   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         rcnt <= 0;
      end else if (!rst_in) begin
         rcnt <= 0;
      end else if (rcnt < RST_CLKS) begin
         rcnt <= rcnt + 1;
      end
   end

   // R1: a latch pulse never lasts more than two clocks
   a_r1_ale_max_width: assert property (@(posedge clk) disable iff (!arst_n)
      (ale && $past(ale)) |=> !ale);

   // R3: the read strobe never lasts more than three clocks
   a_r3_psen_max_width: assert property (@(posedge clk) disable iff (!arst_n)
      (!psen_n && !$past(psen_n) && !$past(psen_n, 2)) |=> psen_n);

   // R3: the two strobes never overlap
   a_r3_strobes_exclusive: assert property (@(posedge clk) disable iff (!arst_n)
      !psen_n |-> !ale);

   // R6: a weak-pullup request never coexists with a latch pulse
   a_r6_wpu_no_ale: assert property (@(posedge clk) disable iff (!arst_n)
      ale_wpu |-> !ale);

   // R8: a sustained low-power mode keeps both strobes inactive
   a_r8_lowpwr_quiet: assert property (@(posedge clk) disable iff (!arst_n)
      ((mode_idle || mode_pdown) && $past(mode_idle || mode_pdown)) |-> (!ale && psen_n));

   // R9: a full-length reset request clears the disable bit
   a_r9_reset_clears_dis: assert property (@(posedge clk) disable iff (!arst_n)
      (rcnt == RST_CLKS) |=> !dis_q);

endmodule

bind xbus_strobe_seq xbs_checker #(.RST_CLKS(RST_CLKS)) u_chk (
   .clk        (clk_osc),
   .arst_n     (arst_n),
   .rst_in     (rst_in),
   .mode_idle  (mode_idle),
   .mode_pdown (mode_pdown),
   .ale        (ale),
   .psen_n     (psen_n),
   .ale_wpu    (ale_wpu),
   .dis_q      (dis_q)
);

// File: tb/test_xbus_strobe_seq.sv
`timescale 1ns/1ps
module test_xbus_strobe_seq;

   localparam int          CYC   = 12;
   localparam int          RSTN  = 24;
   localparam logic [7:0]  DADDR = 8'h8E;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic       arst_n, rst_in;
   logic       cyc_xdata, cyc_code_rd, cyc_ext_exec;
   logic       mode_idle, mode_pdown, mode_emu;
   logic       sfr_we;
   logic [7:0] sfr_addr, sfr_wdata, sfr_rdata;
   logic       ale, psen_n, ale_wpu;

   xbus_strobe_seq i_xbus_strobe_seq (
      .clk_osc      (clk),
      .arst_n       (arst_n),
      .rst_in       (rst_in),
      .cyc_xdata    (cyc_xdata),
      .cyc_code_rd  (cyc_code_rd),
      .cyc_ext_exec (cyc_ext_exec),
      .mode_idle    (mode_idle),
      .mode_pdown   (mode_pdown),
      .mode_emu     (mode_emu),
      .sfr_we       (sfr_we),
      .sfr_addr     (sfr_addr),
      .sfr_wdata    (sfr_wdata),
      .sfr_rdata    (sfr_rdata),
      .ale          (ale),
      .psen_n       (psen_n),
      .ale_wpu      (ale_wpu)
   );

   typedef struct {
      logic       ale;
      logic       psen_n;
      logic       wpu;
      logic [7:0] rdata;
      string      req;
   } exp_t;

   exp_t exp_q[$];
   int   n_chk = 0;
   int   n_err = 0;
   bit   done  = 0;

   // bench model of the requirements
   int   m_t, m_rcnt;
   logic m_x, m_c, m_e, m_dis;

   function automatic exp_t model_out(string req);
      exp_t e;
      logic rst_act, ale_raw, psl, susp, df, lp;
      rst_act = (m_rcnt == RSTN);
      ale_raw = (m_t == 1 || m_t == 2) || ((m_t == 7 || m_t == 8) && !m_x);
      psl     = m_e && !m_x && ((m_t >= 3 && m_t <= 5) || (m_t >= 9 && m_t <= 11));
      susp    = m_e || m_x || m_c || mode_idle || mode_pdown || mode_emu;
      df      = m_dis && !susp;
      lp      = mode_idle || mode_pdown;
      e.ale    = ale_raw && !df && !lp && !rst_act;
      e.psen_n = !(psl && !lp && !rst_act);
      e.wpu    = df && !rst_act;
      e.rdata  = (sfr_addr == DADDR) ? {7'b0, m_dis} : 8'h00;
      e.req    = req;
      return e;
   endfunction

   function automatic void model_update();
      if (m_rcnt == RSTN) begin
         m_t = 0; m_x = 0; m_c = 0; m_e = 0; m_dis = 0;
      end else begin
         if (m_t == CYC - 1) begin
            m_x = cyc_xdata; m_c = cyc_code_rd; m_e = cyc_ext_exec;
         end
         if (sfr_we && sfr_addr == DADDR) m_dis = sfr_wdata[0];
         m_t = (m_t + 1) % CYC;
      end
      m_rcnt = rst_in ? ((m_rcnt < RSTN) ? m_rcnt + 1 : RSTN) : 0;
   endfunction

   // driver: one clock, expected item queued for the monitor
   task automatic step(string req);
      @(negedge clk);
      exp_q.push_back(model_out(req));
      @(posedge clk);
      model_update();
      #1;
   endtask

   task automatic run(int n, string req);
      for (int i = 0; i < n; i++) step(req);
   endtask

   task automatic cycles(int n, string req);
      run(n * CYC, req);
   endtask

   // monitor: pops and compares away from the clock edge
   always @(negedge clk) begin
      exp_t e;
      #1;
      if (exp_q.size() != 0) begin
         e = exp_q.pop_front();
         n_chk++;
         if (ale !== e.ale || psen_n !== e.psen_n || ale_wpu !== e.wpu || sfr_rdata !== e.rdata) begin
            n_err++;
            $display("FAIL %s t=%0d: ale/psen_n/wpu/rdata got %b/%b/%b/%h expected %b/%b/%b/%h",
                     e.req, m_t, ale, psen_n, ale_wpu, sfr_rdata, e.ale, e.psen_n, e.wpu, e.rdata);
         end
      end
   end

   // R10: reset values while the asynchronous reset is held
   task automatic check_reset();
      @(negedge clk);
      #1;
      n_chk++;
      if (ale !== 1'b0 || psen_n !== 1'b1 || ale_wpu !== 1'b0 || sfr_rdata !== 8'h00) begin
         n_err++;
         $display("FAIL R10: ale/psen_n/wpu/rdata got %b/%b/%b/%h expected 0/1/0/00",
                  ale, psen_n, ale_wpu, sfr_rdata);
      end
   endtask

   initial begin
      arst_n = 0; rst_in = 0;
      cyc_xdata = 0; cyc_code_rd = 0; cyc_ext_exec = 0;
      mode_idle = 0; mode_pdown = 0; mode_emu = 0;
      sfr_we = 0; sfr_addr = DADDR; sfr_wdata = 8'h00;
      m_t = 0; m_rcnt = 0; m_x = 0; m_c = 0; m_e = 0; m_dis = 0;
      repeat (3) check_reset();
      @(posedge clk); #1;
      arst_n = 1;

      cycles(2, "R1");
      cyc_ext_exec = 1; cycles(3, "R3");       // takes effect at the boundary (R4)
      cyc_xdata = 1;    cycles(2, "R2");
      cyc_xdata = 0;    cycles(2, "R4");
      cyc_ext_exec = 0; cycles(2, "R3");

      // register port (R5)
      sfr_we = 1; sfr_wdata = 8'hFE; run(1, "R5");
      sfr_addr = 8'h8F; sfr_wdata = 8'h01; run(1, "R5");
      sfr_we = 0; run(1, "R5");
      sfr_addr = DADDR; run(2, "R5");
      sfr_we = 1; sfr_wdata = 8'h01; run(1, "R5");
      sfr_we = 0; run(1, "R5");
      sfr_addr = 8'h80; run(1, "R5");
      sfr_addr = DADDR;

      cycles(2, "R6");
      mode_emu = 1;     cycles(1, "R7");
      mode_emu = 0;     cycles(1, "R6");
      cyc_code_rd = 1;  cycles(2, "R7");
      cyc_code_rd = 0;  cycles(2, "R6");
      cyc_ext_exec = 1; cycles(2, "R7");
      cyc_ext_exec = 0; cycles(2, "R6");
      cyc_xdata = 1;    cycles(2, "R7");
      cyc_xdata = 0;    cycles(2, "R6");

      mode_idle = 1;    cycles(1, "R8");
      mode_idle = 0; cyc_ext_exec = 1; cycles(2, "R3");
      mode_idle = 1;    cycles(1, "R8");
      mode_idle = 0; mode_pdown = 1; cycles(1, "R8");
      mode_pdown = 0; cyc_ext_exec = 0; cycles(2, "R6");

      // reset filter (R9)
      rst_in = 1; run(RSTN - 1, "R9");
      rst_in = 0; cycles(1, "R9");
      rst_in = 1; run(RSTN + 6, "R9");
      rst_in = 0; cycles(2, "R9");

      repeat (3) @(negedge clk);
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: run did not complete, got hang expected finish");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule